// File: doc/BRIEF.md
# Vector Operand Fetch and Writeback Stage

This block sits at the front and back of one instruction slot in a four-lane vector unit. Every lane is a 24-bit value that the block moves and never interprets. On the fetch side it reads two source vectors from one indexed register space. That space holds 16 input registers, 16 temporaries and 96 float constants. The block then rearranges the lanes of each source and can flip their sign. The result is presented to the arithmetic stage as two prepared operands. On the return side it takes a result vector and a destination number, and writes the enabled lanes into either an output register or a temporary.

The way each source is reordered and negated, and which result lanes may be written, comes from an operand-descriptor word. These words sit in a 1024-entry table and are picked by index, not carried in the instruction. Two signed address registers can be loaded from the first source. Either one can then be added to the first source's register number on later instructions, which gives indexed access to constants and inputs.

Top module: `vec_operand_stage`

## Requirements
- R1: While rst_ni is low and after its release: src_valid_o is 0, both source outputs are zero, all output registers, temporaries, inputs, constants and both address registers are zero.
- R2: A request sampled on a rising edge gives src_valid_o = 1 and the prepared operands after that same edge. With no request, src_valid_o returns to 0 after the next edge, and the source outputs keep their last values.
- R3: An effective source number n decodes as follows: 0x00–0x0F reads input n; 0x10–0x1F reads temporary n−0x10; 0x20–0x7F reads constant n−0x20. A negative n, or n ≥ 0x80, reads an all-zero vector.
- R4: Lane c of a vector occupies bits [24c+23:24c], with lane 0 = x and lane 3 = w. Descriptor bits [12:5] hold the first source's selectors and bits [21:14] hold the second's. Each is 2 bits, at offset 2c for output lane c. Values 0..3 pick x..w of the fetched vector.
- R5: Descriptor bit 4 (first source) and bit 13 (second source) each invert bit 23 of all four lanes of that prepared operand.
- R6: A writeback to destination 0x00–0x07 writes output register dest. A destination of 0x10–0x1F writes temporary dest−0x10. Destinations 0x08–0x0F and 0x20–0x7F change no state.
- R7: Writeback lane c is written only if bit c of the writeback descriptor's mask field (bits [3:0]) is set. Other lanes keep their old value.
- R8: Select 1 adds address register 0 and select 2 adds address register 1 to the first source number. Selects 0 and 3 add nothing. The second source number is never offset.
- R9: A request with the load-address flag set loads address register 0 from bits [7:0] and register 1 from bits [31:24] of the prepared first operand, both as signed 8-bit values. Each load happens only if mask bit 0 or 1 respectively is set. The new value offsets the next request.
- R10: A read of a temporary on the same edge that writes it returns the old contents.
- R11: The load port writes inputs (0x00–0x0F) and constants (0x20–0x7F). A load aimed at 0x10–0x1F is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Descriptor table write enable |
| desc_addr_i | input | 10 | Descriptor table write index |
| desc_wdata_i | input | 22 | Descriptor word |
| ld_we_i | input | 1 | Register load enable |
| ld_reg_i | input | 7 | Register number to load |
| ld_vec_i | input | 96 | Vector to load |
| req_valid_i | input | 1 | Fetch request |
| req_src1_i | input | 7 | First source register number |
| req_src2_i | input | 7 | Second source register number |
| req_desc_i | input | 10 | Descriptor index for the fetch |
| req_areg_sel_i | input | 2 | Address register select for the first source |
| req_mova_i | input | 1 | Load address registers from the first operand |
| wb_valid_i | input | 1 | Writeback enable |
| wb_dest_i | input | 7 | Writeback destination number |
| wb_desc_i | input | 10 | Descriptor index giving the write mask |
| wb_vec_i | input | 96 | Result vector |
| out_sel_i | input | 3 | Output register read select |
| out_vec_o | output | 96 | Selected output register |
| src_valid_o | output | 1 | Prepared operands valid |
| src1_o | output | 96 | Prepared first operand |
| src2_o | output | 96 | Prepared second operand |

## Verification
The prepared operands and src_valid_o are due one edge after the request is sampled, so each scenario drives a request on a falling edge and reads the outputs on the next falling edge. Writebacks, loads and address-register loads all take effect on the edge that samples them. Their results are therefore observed through a fresh request, due one further edge later. out_vec_o is combinational from the stored registers and is read a short delay after out_sel_i changes. The same-cycle case puts the write and the read on one edge and expects the old temporary.

// File: rtl/vop_pkg.sv
package vop_pkg;
  localparam int COMP_W     = 24;
  localparam int NUM_COMP   = 4;
  localparam int VEC_W      = COMP_W * NUM_COMP;
  localparam int SEL_W      = $clog2(NUM_COMP);
  localparam int REG_W      = 7;
  localparam int IDX_W      = REG_W + 3;
  localparam int N_IN       = 16;
  localparam int N_TMP      = 16;
  localparam int N_UNI      = 96;
  localparam int N_OUT      = 8;
  localparam int IN_AW      = $clog2(N_IN);
  localparam int TMP_AW     = $clog2(N_TMP);
  localparam int UNI_AW     = $clog2(N_UNI);
  localparam int OUT_AW     = $clog2(N_OUT);
  localparam int TMP_BASE   = N_IN;
  localparam int UNI_BASE   = N_IN + N_TMP;
  localparam int DESC_DEPTH = 1024;
  localparam int DESC_AW    = $clog2(DESC_DEPTH);
  localparam int AREG_W     = 8;
  // descriptor word layout
  localparam int MASK_LSB   = 0;
  localparam int NEG1_BIT   = MASK_LSB + NUM_COMP;
  localparam int SEL1_LSB   = NEG1_BIT + 1;
  localparam int NEG2_BIT   = SEL1_LSB + NUM_COMP * SEL_W;
  localparam int SEL2_LSB   = NEG2_BIT + 1;
  localparam int DESC_W     = SEL2_LSB + NUM_COMP * SEL_W;

  typedef logic [VEC_W-1:0]            vec_t;
  typedef logic [NUM_COMP-1:0]         mask_t;
  typedef logic [NUM_COMP*SEL_W-1:0]   sel_t;
  typedef logic signed [IDX_W-1:0]     idx_t;
endpackage

// File: rtl/vop_desc_mem.sv
module vop_desc_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 22,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [W-1:0]  rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/vop_regfile.sv
module vop_regfile import vop_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_we_i,
  input  logic [REG_W-1:0]  ld_reg_i,
  input  vec_t              ld_vec_i,
  input  logic              tmp_we_i,
  input  logic [TMP_AW-1:0] tmp_idx_i,
  input  mask_t             tmp_mask_i,
  input  vec_t              tmp_vec_i,
  input  idx_t [1:0]        rd_idx_i,
  output vec_t [1:0]        rd_vec_o
);
  vec_t in_q  [N_IN];
  vec_t tmp_q [N_TMP];
  vec_t uni_q [N_UNI];

  logic ld_in, ld_uni;
  assign ld_in  = ld_we_i && (int'(ld_reg_i) < TMP_BASE);
  assign ld_uni = ld_we_i && (int'(ld_reg_i) >= UNI_BASE) && (int'(ld_reg_i) < UNI_BASE + N_UNI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_IN; i++) in_q[i] <= '0;
    end else if (ld_in) begin
      in_q[ld_reg_i[IN_AW-1:0]] <= ld_vec_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_UNI; i++) uni_q[i] <= '0;
    end else if (ld_uni) begin
      uni_q[UNI_AW'(int'(ld_reg_i) - UNI_BASE)] <= ld_vec_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_TMP; i++) tmp_q[i] <= '0;
    end else if (tmp_we_i) begin
      for (int c = 0; c < NUM_COMP; c++)
        if (tmp_mask_i[c])
          tmp_q[tmp_idx_i][c*COMP_W +: COMP_W] <= tmp_vec_i[c*COMP_W +: COMP_W];
    end
  end

  // out-of-space numbers read as zero
  for (genvar p = 0; p < 2; p++) begin : g_rd
    int k;
    always_comb begin
      k = int'($signed(rd_idx_i[p]));
      rd_vec_o[p] = '0;
      if (k >= 0 && k < TMP_BASE)           rd_vec_o[p] = in_q[IN_AW'(k)];
      else if (k >= TMP_BASE && k < UNI_BASE) rd_vec_o[p] = tmp_q[TMP_AW'(k - TMP_BASE)];
      else if (k >= UNI_BASE && k < UNI_BASE + N_UNI)
                                            rd_vec_o[p] = uni_q[UNI_AW'(k - UNI_BASE)];
    end
  end
endmodule

// File: rtl/vop_swz.sv
module vop_swz import vop_pkg::*; (
  input  vec_t vec_i,
  input  sel_t sel_i,
  input  logic neg_i,
  output vec_t vec_o
);
  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [SEL_W-1:0]  sel;
    logic [COMP_W-1:0] pick;
    assign sel  = sel_i[c*SEL_W +: SEL_W];
    assign pick = vec_i[sel*COMP_W +: COMP_W];
    assign vec_o[c*COMP_W +: COMP_W] = {pick[COMP_W-1] ^ neg_i, pick[COMP_W-2:0]};
  end
endmodule

// File: rtl/vop_wb.sv
module vop_wb import vop_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wb_valid_i,
  input  logic [REG_W-1:0]  wb_dest_i,
  input  mask_t             wb_mask_i,
  input  vec_t              wb_vec_i,
  input  logic [OUT_AW-1:0] out_sel_i,
  output logic              tmp_we_o,
  output logic [TMP_AW-1:0] tmp_idx_o,
  output vec_t              out_vec_o
);
  vec_t out_q [N_OUT];
  logic out_we;

  assign out_we    = wb_valid_i && (int'(wb_dest_i) < N_OUT);
  assign tmp_we_o  = wb_valid_i && (int'(wb_dest_i) >= TMP_BASE) &&
                     (int'(wb_dest_i) < TMP_BASE + N_TMP);
  assign tmp_idx_o = TMP_AW'(int'(wb_dest_i) - TMP_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_OUT; i++) out_q[i] <= '0;
    end else if (out_we) begin
      for (int c = 0; c < NUM_COMP; c++)
        if (wb_mask_i[c])
          out_q[wb_dest_i[OUT_AW-1:0]][c*COMP_W +: COMP_W] <= wb_vec_i[c*COMP_W +: COMP_W];
    end
  end

  assign out_vec_o = out_q[out_sel_i];

  // R6
  wb_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({out_we, tmp_we_o}));
endmodule

// File: rtl/vec_operand_stage.sv
module vec_operand_stage import vop_pkg::*; (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                desc_we_i,
  input  logic [DESC_AW-1:0]  desc_addr_i,
  input  logic [DESC_W-1:0]   desc_wdata_i,
  input  logic                ld_we_i,
  input  logic [REG_W-1:0]    ld_reg_i,
  input  logic [VEC_W-1:0]    ld_vec_i,
  input  logic                req_valid_i,
  input  logic [REG_W-1:0]    req_src1_i,
  input  logic [REG_W-1:0]    req_src2_i,
  input  logic [DESC_AW-1:0]  req_desc_i,
  input  logic [1:0]          req_areg_sel_i,
  input  logic                req_mova_i,
  input  logic                wb_valid_i,
  input  logic [REG_W-1:0]    wb_dest_i,
  input  logic [DESC_AW-1:0]  wb_desc_i,
  input  logic [VEC_W-1:0]    wb_vec_i,
  input  logic [OUT_AW-1:0]   out_sel_i,
  output logic [VEC_W-1:0]    out_vec_o,
  output logic                src_valid_o,
  output logic [VEC_W-1:0]    src1_o,
  output logic [VEC_W-1:0]    src2_o
);
  logic [DESC_W-1:0] fdesc, wdesc;
  mask_t             fmask, wmask;
  logic              unused_wdesc;

  vop_desc_mem #(.DEPTH(DESC_DEPTH), .W(DESC_W)) u_desc (
    .clk_i     (clk_i),
    .we_i      (desc_we_i),
    .waddr_i   (desc_addr_i),
    .wdata_i   (desc_wdata_i),
    .raddr_a_i (req_desc_i),
    .rdata_a_o (fdesc),
    .raddr_b_i (wb_desc_i),
    .rdata_b_o (wdesc)
  );

  assign fmask        = fdesc[MASK_LSB +: NUM_COMP];
  assign wmask        = wdesc[MASK_LSB +: NUM_COMP];
  assign unused_wdesc = ^wdesc[DESC_W-1:NUM_COMP];

  // address offset on the first source only
  logic signed [AREG_W-1:0] areg_q [2];
  idx_t off1, eff1, eff2;

  always_comb begin
    case (req_areg_sel_i)
      2'd1:    off1 = IDX_W'(areg_q[0]);
      2'd2:    off1 = IDX_W'(areg_q[1]);
      default: off1 = '0;
    endcase
  end
  assign eff1 = IDX_W'(req_src1_i) + off1;
  assign eff2 = IDX_W'(req_src2_i);

  logic              tmp_we;
  logic [TMP_AW-1:0] tmp_idx;
  vec_t [1:0]        raw;
  vec_t              p1, p2;

  vop_regfile u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_we_i    (ld_we_i),
    .ld_reg_i   (ld_reg_i),
    .ld_vec_i   (ld_vec_i),
    .tmp_we_i   (tmp_we),
    .tmp_idx_i  (tmp_idx),
    .tmp_mask_i (wmask),
    .tmp_vec_i  (wb_vec_i),
    .rd_idx_i   ({eff2, eff1}),
    .rd_vec_o   (raw)
  );

  vop_swz u_swz1 (
    .vec_i (raw[0]),
    .sel_i (fdesc[SEL1_LSB +: NUM_COMP*SEL_W]),
    .neg_i (fdesc[NEG1_BIT]),
    .vec_o (p1)
  );

  vop_swz u_swz2 (
    .vec_i (raw[1]),
    .sel_i (fdesc[SEL2_LSB +: NUM_COMP*SEL_W]),
    .neg_i (fdesc[NEG2_BIT]),
    .vec_o (p2)
  );

  vop_wb u_wb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wb_valid_i (wb_valid_i),
    .wb_dest_i  (wb_dest_i),
    .wb_mask_i  (wmask),
    .wb_vec_i   (wb_vec_i),
    .out_sel_i  (out_sel_i),
    .tmp_we_o   (tmp_we),
    .tmp_idx_o  (tmp_idx),
    .out_vec_o  (out_vec_o)
  );

  logic mova_fire;
  logic valid_q;
  vec_t src1_q, src2_q;

  assign mova_fire = req_valid_i && req_mova_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      src1_q    <= '0;
      src2_q    <= '0;
      areg_q[0] <= '0;
      areg_q[1] <= '0;
    end else begin
      valid_q <= req_valid_i;
      if (req_valid_i) begin
        src1_q <= p1;
        src2_q <= p2;
      end
      if (mova_fire && fmask[0]) areg_q[0] <= p1[AREG_W-1:0];
      if (mova_fire && fmask[1]) areg_q[1] <= p1[COMP_W +: AREG_W];
    end
  end

  assign src_valid_o = valid_q;
  assign src1_o      = src1_q;
  assign src2_o      = src2_q;

  // R2
  valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> src_valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !src_valid_o);
  // R2
  operand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(src1_o) && $stable(src2_o)));
  // R9
  areg0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mova_fire && !fmask[0]) |=> $stable(areg_q[0]));
  // R9
  areg1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mova_fire) |=> $stable(areg_q[1]));
endmodule

// File: tb/vec_operand_stage_test.sv
`timescale 1ns/1ps
module vec_operand_stage_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_we = 0;
  logic [9:0]  desc_addr = '0;
  logic [21:0] desc_wdata = '0;
  logic        ld_we = 0;
  logic [6:0]  ld_reg = '0;
  logic [95:0] ld_vec = '0;
  logic        req_valid = 0;
  logic [6:0]  req_src1 = '0, req_src2 = '0;
  logic [9:0]  req_desc = '0;
  logic [1:0]  req_sel = '0;
  logic        req_mova = 0;
  logic        wb_valid = 0;
  logic [6:0]  wb_dest = '0;
  logic [9:0]  wb_desc = '0;
  logic [95:0] wb_vec = '0;
  logic [2:0]  out_sel = '0;
  logic [95:0] out_vec, src1, src2;
  logic        src_valid;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  vec_operand_stage uut (
    .clk_i(clk), .rst_ni(rst_n),
    .desc_we_i(desc_we), .desc_addr_i(desc_addr), .desc_wdata_i(desc_wdata),
    .ld_we_i(ld_we), .ld_reg_i(ld_reg), .ld_vec_i(ld_vec),
    .req_valid_i(req_valid), .req_src1_i(req_src1), .req_src2_i(req_src2),
    .req_desc_i(req_desc), .req_areg_sel_i(req_sel), .req_mova_i(req_mova),
    .wb_valid_i(wb_valid), .wb_dest_i(wb_dest), .wb_desc_i(wb_desc), .wb_vec_i(wb_vec),
    .out_sel_i(out_sel), .out_vec_o(out_vec),
    .src_valid_o(src_valid), .src1_o(src1), .src2_o(src2)
  );

  function automatic logic [95:0] v4(logic [23:0] x, logic [23:0] y, logic [23:0] z, logic [23:0] w);
    return {w, z, y, x};
  endfunction

  function automatic logic [21:0] mkd(logic [3:0] m, logic n1, logic [7:0] s1, logic n2, logic [7:0] s2);
    return {s2, n2, s1, n1, m};
  endfunction

  task automatic chk(string r, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic put_desc(logic [9:0] a, logic [21:0] d);
    @(negedge clk); desc_we = 1; desc_addr = a; desc_wdata = d;
    @(negedge clk); desc_we = 0;
  endtask

  task automatic put_reg(logic [6:0] r, logic [95:0] v);
    @(negedge clk); ld_we = 1; ld_reg = r; ld_vec = v;
    @(negedge clk); ld_we = 0;
  endtask

  task automatic issue(logic [6:0] s1, logic [6:0] s2, logic [9:0] d, logic [1:0] sel, logic mova);
    @(negedge clk); req_valid = 1; req_src1 = s1; req_src2 = s2; req_desc = d; req_sel = sel; req_mova = mova;
    @(negedge clk); req_valid = 0; req_mova = 0;
  endtask

  task automatic wback(logic [6:0] dest, logic [9:0] d, logic [95:0] v);
    @(negedge clk); wb_valid = 1; wb_dest = dest; wb_desc = d; wb_vec = v;
    @(negedge clk); wb_valid = 0;
  endtask

  task automatic read_out(logic [2:0] s, output logic [95:0] v);
    out_sel = s; #1; v = out_vec;
  endtask

  localparam logic [7:0] ID = 8'hE4;
  logic [95:0] va, vu, vb, vc, vw, vz, vk;
  logic [95:0] tmp;

  task automatic t_reset;
    chk("R1 valid", {95'b0, src_valid}, 96'd0);
    chk("R1 src1", src1, '0);
    chk("R1 src2", src2, '0);
    read_out(3'd0, tmp); chk("R1 out0", tmp, '0);
  endtask

  task automatic t_decode;
    put_reg(7'h03, va);                 // R11 input load
    put_reg(7'h25, vu);
    put_desc(10'd0, mkd(4'hF, 0, ID, 0, ID));
    issue(7'h03, 7'h25, 10'd0, 2'd0, 0);
    chk("R2 valid", {95'b0, src_valid}, 96'd1);
    chk("R3 input", src1, va);
    chk("R3 uniform", src2, vu);
    @(negedge clk);
    chk("R2 idle", {95'b0, src_valid}, 96'd0);
    chk("R2 hold", src1, va);
  endtask

  task automatic t_swizzle;
    put_desc(10'd1, mkd(4'hF, 0, 8'h1B, 1, 8'h55));
    issue(7'h03, 7'h03, 10'd1, 2'd0, 0);
    chk("R4 reverse", src1, v4(24'h400004, 24'h300003, 24'h200002, 24'h100001));
    chk("R5 neg2 splat", src2, v4(24'hA00002, 24'hA00002, 24'hA00002, 24'hA00002));
    put_reg(7'h07, v4(24'h800010, 24'h000020, 24'h800030, 24'h000040));
    put_desc(10'd9, mkd(4'hF, 1, ID, 0, 8'h00));
    issue(7'h07, 7'h03, 10'd9, 2'd0, 0);
    chk("R5 neg1", src1, v4(24'h000010, 24'h800020, 24'h000030, 24'h800040));
    chk("R4 splat x", src2, v4(24'h100001, 24'h100001, 24'h100001, 24'h100001));
  endtask

  task automatic t_writeback;
    put_desc(10'd2, mkd(4'h5, 0, ID, 0, ID));
    wback(7'h12, 10'd2, vw);
    issue(7'h12, 7'h03, 10'd0, 2'd0, 0);
    chk("R7 mask 0101", src1, v4(24'h111111, 24'h0, 24'h333333, 24'h0));
    wback(7'h05, 10'd0, vw);
    read_out(3'd5, tmp); chk("R6 out5", tmp, vw);
  endtask

  task automatic t_discard;
    wback(7'h0A, 10'd0, vz);
    wback(7'h25, 10'd0, vz);
    wback(7'h7F, 10'd0, vz);
    read_out(3'd2, tmp); chk("R6 drop 0x0A out", tmp, '0);
    read_out(3'd7, tmp); chk("R6 drop 0x7F out", tmp, '0);
    issue(7'h15, 7'h1A, 10'd0, 2'd0, 0);
    chk("R6 drop temp5", src1, '0);
    chk("R6 drop temp10", src2, '0);
    issue(7'h25, 7'h03, 10'd0, 2'd0, 0);
    chk("R6 uniform untouched", src1, vu);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wb_valid = 1; wb_dest = 7'h13; wb_desc = 10'd0; wb_vec = vc;
    req_valid = 1; req_src1 = 7'h13; req_src2 = 7'h13; req_desc = 10'd0; req_sel = 2'd0;
    @(negedge clk); wb_valid = 0; req_valid = 0;
    chk("R10 old value", src1, '0);
    issue(7'h13, 7'h03, 10'd0, 2'd0, 0);
    chk("R10 new value", src1, vc);
  endtask

  task automatic t_load_port;
    put_reg(7'h14, vz);
    issue(7'h14, 7'h03, 10'd0, 2'd0, 0);
    chk("R11 temp load ignored", src1, '0);
    put_reg(7'h7F, vk);
    issue(7'h7F, 7'h03, 10'd0, 2'd0, 0);
    chk("R11 top uniform", src1, vk);
  endtask

  task automatic t_offset;
    put_reg(7'h04, vb);
    put_reg(7'h06, vc);
    put_reg(7'h30, v4(24'd1, 24'd2, 24'd0, 24'd0));
    put_desc(10'd3, mkd(4'h3, 0, ID, 0, ID));
    issue(7'h30, 7'h00, 10'd3, 2'd0, 1);     // areg0=1 areg1=2
    issue(7'h03, 7'h03, 10'd0, 2'd1, 0);
    chk("R8 sel1", src1, vb);
    chk("R8 src2 not offset", src2, va);
    issue(7'h04, 7'h03, 10'd0, 2'd2, 0);
    chk("R8 sel2", src1, vc);
    issue(7'h04, 7'h03, 10'd0, 2'd0, 0);
    chk("R8 sel0", src1, vb);
    issue(7'h04, 7'h03, 10'd0, 2'd3, 0);
    chk("R8 sel3", src1, vb);
    put_reg(7'h31, v4(24'hFFFFFF, 24'd7, 24'd0, 24'd0));
    put_desc(10'd4, mkd(4'h1, 0, ID, 0, ID));
    issue(7'h31, 7'h00, 10'd4, 2'd0, 1);     // areg0=-1, areg1 kept
    issue(7'h04, 7'h03, 10'd0, 2'd1, 0);
    chk("R9 areg0 negative", src1, va);
    issue(7'h04, 7'h03, 10'd0, 2'd2, 0);
    chk("R9 areg1 masked", src1, vc);
  endtask

  task automatic t_dummy;
    issue(7'h00, 7'h03, 10'd0, 2'd1, 0);     // 0 + (-1)
    chk("R3 negative index", src1, '0);
    put_reg(7'h32, v4(24'd127, 24'd0, 24'd0, 24'd0));
    put_reg(7'h7E, vb);
    issue(7'h32, 7'h00, 10'd4, 2'd0, 1);     // areg0=127
    issue(7'h7F, 7'h03, 10'd0, 2'd1, 0);     // 254
    chk("R3 index past top", src1, '0);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    va = v4(24'h100001, 24'h200002, 24'h300003, 24'h400004);
    vu = v4(24'h0A0001, 24'h0B0002, 24'h0C0003, 24'h0D0004);
    vb = v4(24'h0B0B01, 24'h0B0B02, 24'h0B0B03, 24'h0B0B04);
    vc = v4(24'h0C0C01, 24'h0C0C02, 24'h0C0C03, 24'h0C0C04);
    vw = v4(24'h111111, 24'h222222, 24'h333333, 24'h444444);
    vz = v4(24'hABCDEF, 24'hABCDEF, 24'hABCDEF, 24'hABCDEF);
    vk = v4(24'h5A5A01, 24'h5A5A02, 24'h5A5A03, 24'h5A5A04);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_swizzle();
    t_writeback();
    t_discard();
    t_same_cycle();
    t_load_port();
    t_offset();
    t_dummy();
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule